// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block is the sending half of a FIFO-buffered asynchronous serial port. Software or a bus agent writes characters into a 16-entry queue. A frame engine takes them one at a time and sends each on the serial line. A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then the stop period. The line rests high between frames. The character length, the parity rule and the stop length are set at run time. Each frame latches the settings that are present when that frame is loaded.

Bit timing comes from an internal divisor counter. It produces one enable pulse for every `divisor` clocks, and each bit lasts 16 of these pulses. Frames in the queue go out back to back, with no idle gap between them. Optional hardware flow control holds off the start of a new frame while the clear-to-send input is inactive. A break input forces the line low. A loop-back switch sends the serial stream to the local receiver input instead of to the pin. Two level interrupts, each with its own enable, report an empty queue and a fully drained transmitter.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `fill_level` is 0, `rx_core` follows `rxd`, and each interrupt output equals its enable one clock later.
- R2: A frame starts with one low bit of 16 ticks. Then come N data bits, least significant first, where N = 5 + `cfg_len` (codes 0..3 give 5..8 bits). Data bits above N are not sent.
- R3: `cfg_par` selects the parity bit that follows the data. Code 0 sends no parity bit. Code 1 makes the total count of ones odd and code 2 makes it even; both count over the N sent data bits. Code 3 sends a constant 1 and code 4 sends a constant 0. Codes 5 to 7 act as code 0.
- R4: The stop period is high. It lasts 16 ticks when `cfg_stop_long` is 0. When `cfg_stop_long` is 1, it lasts 24 ticks for 5-bit characters and 32 ticks for 6, 7 or 8-bit characters.
- R5: The bit-timing enable pulses once every `divisor` clocks. A divisor of 0 stops all transmission and the line stays high.
- R6: The queue holds 16 characters. `fill_level` shows the count. A write while the queue is full is dropped.
- R7: While characters are waiting, the start of the next frame follows the last stop tick of the previous frame directly. The spacing from one start edge to the next is exactly the frame length in ticks times `divisor` clocks.
- R8: With `afc_en` at 1, no frame starts while `cts` is 0, and a frame already running completes. With `afc_en` at 0, `cts` has no effect.
- R9: While `brk` is 1, `txd` is 0 from the next clock onward, regardless of any frame in progress.
- R10: `irq_empty` is `ie_empty` AND queue-empty. `irq_idle` is `ie_idle` AND queue-empty AND no frame in progress. Both are registered.
- R11: With `loop_en` at 1, `txd` is held at 1 and the serial stream appears on `rx_core`. With `loop_en` at 0, `rx_core` follows `rxd` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 16 | Clocks per bit-timing tick; 0 halts |
| cfg_len | input | 2 | Character length code (N = 5 + code) |
| cfg_par | input | 3 | Parity rule code |
| cfg_stop_long | input | 1 | Long stop period select |
| brk | input | 1 | Force line low |
| afc_en | input | 1 | Hardware flow control enable |
| cts | input | 1 | Far end ready (1 = ready), asynchronous |
| loop_en | input | 1 | Internal loop-back enable |
| rxd | input | 1 | Serial input from the pin |
| ie_empty | input | 1 | Queue-empty interrupt enable |
| ie_idle | input | 1 | Transmitter-drained interrupt enable |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Character to queue |
| fill_level | output | 5 | Characters in queue |
| txd | output | 1 | Serial line output |
| rx_core | output | 1 | Serial input toward the local receiver |
| irq_empty | output | 1 | Queue-empty interrupt |
| irq_idle | output | 1 | Transmitter-drained interrupt |

## Verification
A wrong bit counter or format latch shows up within one frame. A data, parity or stop sample then lands on the wrong level at the middle of a bit. A stop-length or reload fault can leave every bit correct, so it only shows up in the spacing between back-to-back start edges. The bench therefore measures that spacing to the exact clock. Queue pointer faults appear as a wrong `fill_level`, or as a missing or extra frame, within one queue-draining pass. Flow-control and break faults show up as line activity during a window where the line must stay quiet.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned OVERSAMPLE = 16;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = divisor - 1'b1;
  assign tick = (divisor != '0) && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (divisor == '0) begin
      cnt <= '0;
    end else if (cnt >= last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && divisor > 1 && $stable(divisor)) |=> !tick);
endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic [AW:0]  level,
  output logic         empty,
  output logic         full
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         push, pop;

  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign level   = wp - rp;
  assign empty   = (wp == rp);
  assign full    = (level == FULL_LVL);
  assign rd_data = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  // R6
  fifo_level_chk: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);
  // R6
  fifo_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (level == FULL_LVL));
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       can_go,
  input  logic [7:0] din,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic       cfg_stop_long,
  output logic       pop,
  output logic       ser,
  output logic       idle
);
  localparam logic [4:0] BIT_LAST = 5'(OVERSAMPLE - 1);

  tx_state_e  st;
  logic [4:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] shr;
  logic [1:0] len_q;
  logic [2:0] par_q;
  logic       stop_long_q;
  logic       par_bit;

  logic [2:0] nbits_m1;
  logic       has_par;
  logic [4:0] stop_last;
  logic       load;
  logic [7:0] mask;
  logic       ones_par;
  logic       par_calc;

  assign nbits_m1  = 3'd4 + {1'b0, len_q};
  assign has_par   = (par_q >= PAR_ODD) && (par_q <= PAR_SPACE);
  assign stop_last = !stop_long_q ? BIT_LAST : ((len_q == 2'd0) ? 5'd23 : 5'd31);
  assign load      = tick && can_go &&
                     ((st == ST_IDLE) || ((st == ST_STOP) && (tcnt == stop_last)));
  assign pop       = load;
  assign idle      = (st == ST_IDLE);

  assign mask     = 8'hFF >> (2'd3 - cfg_len);
  assign ones_par = ^(din & mask);

  always_comb begin
    case (cfg_par)
      PAR_ODD:   par_calc = ~ones_par;
      PAR_EVEN:  par_calc = ones_par;
      PAR_MARK:  par_calc = 1'b1;
      default:   par_calc = 1'b0;
    endcase
  end

  always_comb begin
    case (st)
      ST_START: ser = 1'b0;
      ST_DATA:  ser = shr[0];
      ST_PAR:   ser = par_bit;
      default:  ser = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      tcnt        <= '0;
      bidx        <= '0;
      shr         <= '0;
      len_q       <= '0;
      par_q       <= PAR_NONE;
      stop_long_q <= 1'b0;
      par_bit     <= 1'b0;
    end else if (tick) begin
      if (load) begin
        st          <= ST_START;
        tcnt        <= '0;
        bidx        <= '0;
        shr         <= din;
        len_q       <= cfg_len;
        par_q       <= cfg_par;
        stop_long_q <= cfg_stop_long;
        par_bit     <= par_calc;
      end else begin
        case (st)
          ST_START: begin
            if (tcnt == BIT_LAST) begin
              st   <= ST_DATA;
              tcnt <= '0;
            end else tcnt <= tcnt + 1'b1;
          end
          ST_DATA: begin
            if (tcnt == BIT_LAST) begin
              tcnt <= '0;
              shr  <= shr >> 1;
              if (bidx == nbits_m1) st <= has_par ? ST_PAR : ST_STOP;
              else bidx <= bidx + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          end
          ST_PAR: begin
            if (tcnt == BIT_LAST) begin
              st   <= ST_STOP;
              tcnt <= '0;
            end else tcnt <= tcnt + 1'b1;
          end
          ST_STOP: begin
            if (tcnt == stop_last) begin
              st   <= ST_IDLE;
              tcnt <= '0;
            end else tcnt <= tcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  data_index_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA) |-> (bidx <= nbits_m1));
  // R4
  stop_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP) |-> (tcnt <= stop_last));
  // R5
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick) |=> $stable(st));
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        cfg_len,
  input  logic [2:0]        cfg_par,
  input  logic              cfg_stop_long,
  input  logic              brk,
  input  logic              afc_en,
  input  logic              cts,
  input  logic              loop_en,
  input  logic              rxd,
  input  logic              ie_empty,
  input  logic              ie_idle,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LVL_W-1:0]  fill_level,
  output logic              txd,
  output logic              rx_core,
  output logic              irq_empty,
  output logic              irq_idle
);
  logic              tick;
  logic              fifo_empty, fifo_full;
  logic [DATA_W-1:0] fifo_q;
  logic              frame_pop, frame_ser, frame_idle;
  logic [1:0]        cts_sync;
  logic              cts_s;
  logic              can_go;
  logic              line;

  assign cts_s  = cts_sync[1];
  assign can_go = !fifo_empty && (!afc_en || cts_s);
  assign line   = brk ? 1'b0 : frame_ser;

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .divisor (divisor),
    .tick    (tick)
  );

  sertx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (frame_pop),
    .rd_data (fifo_q),
    .level   (fill_level),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  sertx_frame u_frame (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .can_go        (can_go),
    .din           (fifo_q[7:0]),
    .cfg_len       (cfg_len),
    .cfg_par       (cfg_par),
    .cfg_stop_long (cfg_stop_long),
    .pop           (frame_pop),
    .ser           (frame_ser),
    .idle          (frame_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_sync  <= '0;
      txd       <= 1'b1;
      rx_core   <= 1'b1;
      irq_empty <= 1'b0;
      irq_idle  <= 1'b0;
    end else begin
      cts_sync  <= {cts_sync[0], cts};
      txd       <= loop_en ? 1'b1 : line;
      rx_core   <= loop_en ? line : rxd;
      irq_empty <= ie_empty && fifo_empty;
      irq_idle  <= ie_idle && fifo_empty && frame_idle;
    end
  end

  // R9
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (brk && !loop_en) |=> !txd);
  // R8
  afc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_pop && afc_en) |-> cts_s);
  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    frame_pop |-> !fifo_empty);
  // R11
  loop_high_chk: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> txd);
  // R6
  full_level_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> (fill_level == LVL_W'(FIFO_DEPTH)));
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  typedef struct {
    logic [7:0] data;
    int         nbits;
    bit         has_par;
    logic       pbit;
    int         len_cyc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] divisor = '0;
  logic [1:0]  cfg_len = 2'd3;
  logic [2:0]  cfg_par = 3'd0;
  logic        cfg_stop_long = 1'b0;
  logic        brk = 1'b0, afc_en = 1'b0, cts = 1'b1, loop_en = 1'b0, rxd = 1'b1;
  logic        ie_empty = 1'b1, ie_idle = 1'b1, wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [4:0]  fill_level;
  logic        txd, rx_core, irq_empty, irq_idle;

  int   tests = 0, fails = 0, cyc = 0, div_now = 0;
  bit   mon_on = 1'b1, mon_sel = 1'b0, loop_chk = 1'b0;
  int   loop_bad = 0;
  exp_t q[$];
  logic mon_src;

  assign mon_src = mon_sel ? rx_core : txd;

  sertx_top u_dut (
    .clk(clk), .rst(rst), .divisor(divisor), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop_long(cfg_stop_long), .brk(brk), .afc_en(afc_en), .cts(cts),
    .loop_en(loop_en), .rxd(rxd), .ie_empty(ie_empty), .ie_idle(ie_idle),
    .wr_en(wr_en), .wr_data(wr_data), .fill_level(fill_level), .txd(txd),
    .rx_core(rx_core), .irq_empty(irq_empty), .irq_idle(irq_idle)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (loop_chk && txd !== 1'b1) loop_bad <= loop_bad + 1;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic set_div(input int d);
    div_now = d;
    divisor = d[15:0];
  endtask

  task automatic send(input logic [7:0] d, input bit more, input bit expect_it);
    exp_t it;
    logic [7:0] m;
    int stk;
    it.nbits   = 5 + int'(cfg_len);
    m          = 8'hFF >> (8 - it.nbits);
    it.data    = d & m;
    it.has_par = (cfg_par >= 3'd1) && (cfg_par <= 3'd4);
    case (cfg_par)
      3'd1:    it.pbit = ~(^it.data);
      3'd2:    it.pbit = ^it.data;
      3'd3:    it.pbit = 1'b1;
      default: it.pbit = 1'b0;
    endcase
    stk = !cfg_stop_long ? 16 : (it.nbits == 5 ? 24 : 32);
    it.len_cyc = more ? (16 * (1 + it.nbits + int'(it.has_par)) + stk) * div_now : 0;
    if (expect_it) q.push_back(it);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (13 * 16 * div_now + 20) @(negedge clk);
  endtask

  task automatic burst(input logic [1:0] l, input logic [2:0] p, input logic sl,
                       input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    cfg_len = l; cfg_par = p; cfg_stop_long = sl;
    send(a, 1'b1, 1'b1);
    send(b, 1'b1, 1'b1);
    send(c, 1'b0, 1'b1);
    drain();
  endtask

  // scoreboard monitor: pops one expected frame per start edge
  initial begin : monitor
    logic prev;
    int   last_t, last_len, bit_cyc;
    exp_t it;
    prev = 1'b1; last_t = 0; last_len = 0;
    forever begin
      @(negedge clk);
      if (!mon_on || rst) begin
        last_len = 0;
      end else if (prev && !mon_src) begin
        bit_cyc = 16 * div_now;
        if (last_len != 0) chk("R4 R7 start-to-start spacing", cyc - last_t, last_len);
        if (q.size() == 0) begin
          chk("R5 R8 unexpected frame start", 1, 0);
        end else begin
          it = q.pop_front();
          last_t = cyc;
          last_len = it.len_cyc;
          repeat (bit_cyc / 2) @(negedge clk);
          chk("R2 start bit", int'(mon_src), 0);
          for (int i = 0; i < it.nbits; i++) begin
            repeat (bit_cyc) @(negedge clk);
            chk("R2 data bit", int'(mon_src), int'(it.data[i]));
          end
          if (it.has_par) begin
            repeat (bit_cyc) @(negedge clk);
            chk("R3 parity bit", int'(mon_src), int'(it.pbit));
          end
          repeat (bit_cyc) @(negedge clk);
          chk("R4 stop level", int'(mon_src), 1);
        end
      end
      prev = mon_src;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : driver
    int cnt;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 txd idle", int'(txd), 1);
    chk("R1 fill level", int'(fill_level), 0);
    chk("R1 irq_empty", int'(irq_empty), 1);
    chk("R1 irq_idle", int'(irq_idle), 1);
    chk("R1 rx_core follows rxd", int'(rx_core), 1);

    // R10 interrupts with halted tick (R5)
    set_div(0);
    send(8'h5A, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R10 irq_empty low with queued byte", int'(irq_empty), 0);
    chk("R10 irq_idle low with queued byte", int'(irq_idle), 0);
    repeat (200) @(negedge clk);
    chk("R5 divisor 0 keeps line high", int'(txd), 1);
    chk("R5 divisor 0 keeps byte queued", int'(fill_level), 1);
    set_div(1);
    repeat (40) @(negedge clk);
    chk("R10 irq_empty high while sending", int'(irq_empty), 1);
    chk("R10 irq_idle low while sending", int'(irq_idle), 0);
    drain();
    chk("R10 irq_idle high when drained", int'(irq_idle), 1);
    ie_empty = 1'b0; ie_idle = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 irq_empty masked", int'(irq_empty), 0);
    chk("R10 irq_idle masked", int'(irq_idle), 0);
    ie_empty = 1'b1; ie_idle = 1'b1;

    // R2 R3 R4 R7 formats
    burst(2'd3, 3'd0, 1'b0, 8'hA5, 8'h3C, 8'hFF);
    burst(2'd0, 3'd2, 1'b1, 8'hF3, 8'h01, 8'h1E);
    burst(2'd1, 3'd1, 1'b1, 8'h2D, 8'hC0, 8'h15);
    burst(2'd2, 3'd3, 1'b0, 8'h7F, 8'h80, 8'h33);
    burst(2'd3, 3'd4, 1'b1, 8'h96, 8'h00, 8'hE1);
    burst(2'd3, 3'd2, 1'b0, 8'h81, 8'h7E, 8'h6B);
    burst(2'd0, 3'd6, 1'b0, 8'h0A, 8'h15, 8'h1F);

    // R5 slower tick
    set_div(3);
    burst(2'd3, 3'd1, 1'b0, 8'h4E, 8'hB1, 8'h22);
    set_div(1);

    // R6 fill to capacity, overflow dropped
    set_div(0);
    cfg_len = 2'd3; cfg_par = 3'd0; cfg_stop_long = 1'b0;
    for (int i = 0; i < 17; i++) send(8'(i * 7 + 3), i < 15, i < 16);
    repeat (2) @(negedge clk);
    chk("R6 level at capacity", int'(fill_level), 16);
    set_div(1);
    drain();
    chk("R6 queue empty after drain", int'(fill_level), 0);
    chk("R6 overflow byte not sent", q.size(), 0);

    // R8 flow control
    afc_en = 1'b1; cts = 1'b0;
    send(8'hC3, 1'b0, 1'b1);
    repeat (300) @(negedge clk);
    chk("R8 held by cts", int'(fill_level), 1);
    chk("R8 line idle while held", int'(txd), 1);
    cts = 1'b1;
    drain();
    send(8'h69, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    cts = 1'b0;
    drain();
    chk("R8 running frame completed", q.size(), 0);
    afc_en = 1'b0;
    send(8'h12, 1'b0, 1'b1);
    drain();
    chk("R8 cts ignored when disabled", q.size(), 0);
    cts = 1'b1;

    // R9 break
    mon_on = 1'b0;
    brk = 1'b1;
    repeat (2) @(negedge clk);
    cnt = 0;
    repeat (40) begin @(negedge clk); if (txd !== 1'b0) cnt++; end
    chk("R9 line low during break", cnt, 0);
    brk = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 line released", int'(txd), 1);
    send(8'hFF, 1'b0, 1'b0);
    repeat (60) @(negedge clk);
    brk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 break overrides frame", int'(txd), 0);
    repeat (300) @(negedge clk);
    chk("R9 break held past frame end", int'(txd), 0);
    brk = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 line high after break", int'(txd), 1);
    mon_on = 1'b1;

    // R11 loop-back
    loop_en = 1'b1;
    repeat (2) @(negedge clk);
    mon_sel = 1'b1; loop_chk = 1'b1;
    cfg_len = 2'd3; cfg_par = 3'd2; cfg_stop_long = 1'b0;
    send(8'hB4, 1'b1, 1'b1);
    send(8'h4B, 1'b0, 1'b1);
    drain();
    loop_chk = 1'b0;
    chk("R11 txd held high in loop-back", loop_bad, 0);
    loop_en = 1'b0;
    repeat (2) @(negedge clk);
    mon_sel = 1'b0;
    rxd = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 rx_core follows rxd", int'(rx_core), 0);
    rxd = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 rx_core follows rxd high", int'(rx_core), 1);

    chk("R2 scoreboard empty at end", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule